// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the three event flags of one timer: counter overflow, compare match against the A threshold, and compare match against the B threshold. The timer logic sends a one-cycle pulse for each event, and that pulse sets the matching flag. Software clears a flag by writing a one to its bit. The interrupt controller clears a flag when it reports that it has started the flag's vector. Each flag is gated with its own enable bit and with the global interrupt enable, giving three interrupt request lines.

The CPU can reach the register in two ways. A data-space load or store uses data address 0x35. An I/O-port instruction uses port address 0x15, which is the data address minus 0x20. I/O-port accesses only cover the window 0x00 to 0x3F. The block contains no counter, no compare unit and no enable register; the enables arrive as inputs.

Top module: `tif_flag_reg`

## Requirements
- R1: After reset all three flags are 0, so a read of the register returns 0x00 and all interrupt requests are low.
- R2: A data-space read (`bus_io_i`=0) at address 0x35 returns the flags in bits [2:0] with bits [7:3] as zero. Bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. `bus_rdata_o` is 0x00 whenever no read hits the register.
- R3: An I/O-port access (`bus_io_i`=1) at port 0x15 reaches the same register. An I/O-port access at an address of 0x40 or above decodes nothing. A data-space access at 0x15 does not reach the register.
- R4: An event pulse on `evt_i[k]` sets flag k at the next rising clock edge.
- R5: A write that hits the register clears each flag whose data bit is 1. A flag whose data bit is 0 is left unchanged.
- R6: `ack_i[k]` clears flag k only. `ack_i` is one-hot or zero.
- R7: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o[k]` is high exactly when flag k, `irq_en_i[k]` and `gie_i` are all 1.
- R9: A read returns the flag values as they stand before the clock edge on which any write, acknowledge or event of that same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Access address (a data-space address or an I/O port) |
| bus_io_i | input | 1 | 1 = I/O-port access, 0 = data-space access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the same cycle as the strobe |
| evt_i | input | 3 | Event pulses: [0] overflow, [1] compare A, [2] compare B |
| ack_i | input | 3 | Vector acknowledge, one-hot per source |
| irq_en_i | input | 3 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 3 | Interrupt requests |

## Verification
A flag held in the wrong state is seen on `irq_o` in the same cycle once that source and the global enable are on. It is also seen on the next read at either address. The bench therefore keeps the enables high for most of the run and compares both outputs on every cycle, which catches a corrupted flag at most one clock after the faulty edge. Errors in address decoding show up as read data that is non-zero or zero when it should not be, or as a clear that does or does not happen. These are checked with data-space and I/O-port accesses to the register address, to the other form of that address and to an I/O address outside the window.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMPA = 1;
  localparam int SRC_CMPB = 2;
endpackage

// File: rtl/tif_decode.sv
module tif_decode #(
  parameter int ADDR_W    = 12,
  parameter int DATA_ADDR = 'h35,
  parameter int IO_OFFSET = 'h20,
  parameter int IO_SPAN   = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              sel_rd_o,
  output logic              sel_wr_o
);
  localparam logic [ADDR_W-1:0] DS_ADDR = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] IO_ADDR = ADDR_W'(DATA_ADDR - IO_OFFSET);
  localparam logic [ADDR_W-1:0] IO_LIM  = ADDR_W'(IO_SPAN);

  logic ds_hit, io_hit, hit;

  always_comb begin
    ds_hit = !io_i && (addr_i == DS_ADDR);
    io_hit = io_i && (addr_i < IO_LIM) && (addr_i == IO_ADDR);
    hit    = ds_hit || io_hit;
  end

  assign sel_rd_o = hit && rd_i;
  assign sel_wr_o = hit && wr_i;

  // port window ends at IO_SPAN
  p_io_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_i && addr_i >= IO_LIM) |-> !(sel_rd_o || sel_wr_o));
endmodule

// File: rtl/tif_flag.sv
module tif_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  // set has priority so no event is dropped
  always_comb flag_d = set_i | (flag_q & ~(clr_i | ack_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_evt_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i || ack_i) && !set_i) |=> !flag_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && !ack_i) |=> $stable(flag_o));
endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic [N-1:0] irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_gate
    assign irq_o[k] = flag_i[k] & en_i[k] & gie_i;
  end
endmodule

// File: rtl/tif_flag_reg.sv
module tif_flag_reg
  import tif_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int DATA_ADDR = 'h35,
  parameter int IO_OFFSET = 'h20,
  parameter int IO_SPAN   = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_io_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] ack_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic              gie_i,
  output logic [NUM_SRC-1:0] irq_o
);
  logic sel_rd, sel_wr;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] w1c;

  tif_decode #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
    .IO_OFFSET(IO_OFFSET), .IO_SPAN(IO_SPAN)
  ) u_dec (
    .clk_i, .rst_ni,
    .addr_i  (bus_addr_i),
    .io_i    (bus_io_i),
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .sel_rd_o(sel_rd),
    .sel_wr_o(sel_wr)
  );

  assign w1c = sel_wr ? bus_wdata_i[NUM_SRC-1:0] : '0;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    tif_flag u_flag (
      .clk_i, .rst_ni,
      .set_i (evt_i[k]),
      .clr_i (w1c[k]),
      .ack_i (ack_i[k]),
      .flag_o(flags[k])
    );
  end

  // read path is combinational: pre-edge value
  assign bus_rdata_o = sel_rd ? DATA_W'(flags) : '0;

  tif_irq_gate #(.N(NUM_SRC)) u_gate (
    .flag_i(flags), .en_i(irq_en_i), .gie_i(gie_i), .irq_o(irq_o)
  );

  p_ack_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));
  p_ack_only_own_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[SRC_OVF] && !sel_wr && evt_i == '0) |=>
      (flags[SRC_CMPB:SRC_CMPA] == $past(flags[SRC_CMPB:SRC_CMPA])));
  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~flags) == '0);
endmodule

// File: tb/tif_flag_reg_test.sv
module tif_flag_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic        io = 0, rd = 0, wr = 0, gie = 0;
  logic [7:0]  wdata = '0, rdata;
  logic [2:0]  evt = '0, ack = '0, en = '0, irq;

  int checks = 0, fails = 0;
  logic [2:0] m_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tif_flag_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_io_i(io),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .evt_i(evt), .ack_i(ack), .irq_en_i(en), .gie_i(gie), .irq_o(irq)
  );

  function automatic bit model_hit();
    return (!io && addr == 12'h035) || (io && addr == 12'h015);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare mid-cycle, advance model at posedge
  task automatic cyc(string tag, logic [11:0] a, logic i, logic r, logic w,
                     logic [7:0] d, logic [2:0] e, logic [2:0] k);
    logic [2:0] clr;
    addr = a; io = i; rd = r; wr = w; wdata = d; evt = e; ack = k;
    #(CLK_PERIOD/4);
    chk({tag, " rdata"}, rdata, (r && model_hit()) ? {5'b0, m_flags} : 8'h00);
    chk({tag, " irq"}, {5'b0, irq}, {5'b0, m_flags & en & {3{gie}}});
    clr = (w && model_hit()) ? d[2:0] : 3'b0;
    @(posedge clk);
    m_flags = e | (m_flags & ~clr & ~k);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 12'h000, 0, 0, 0, 8'h00, 3'b000, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    en = 3'b111; gie = 1;
    // R1 reset value
    cyc("R1", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    rst_n = 1;
    cyc("R1", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R4 each event sets its own flag; R2 bit positions
    cyc("R4", 12'h000, 0, 0, 0, 8'h00, 3'b001, 3'b000);
    cyc("R2", 12'h035, 0, 1, 0, 8'h00, 3'b010, 3'b000);
    cyc("R2", 12'h035, 0, 1, 0, 8'h00, 3'b100, 3'b000);
    cyc("R2", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R3 I/O access at port 0x15, and aliases that must miss
    cyc("R3", 12'h015, 1, 1, 0, 8'h00, 3'b000, 3'b000);
    cyc("R3", 12'h015, 0, 1, 1, 8'hff, 3'b000, 3'b000);
    cyc("R3", 12'h035, 1, 1, 1, 8'hff, 3'b000, 3'b000);
    cyc("R3", 12'h055, 1, 1, 1, 8'hff, 3'b000, 3'b000);
    cyc("R3", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R5 write-one clears only selected bits; R9 read during write sees old value
    cyc("R9", 12'h035, 0, 1, 1, 8'h02, 3'b000, 3'b000);
    cyc("R5", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    cyc("R5", 12'h015, 1, 1, 1, 8'hf8, 3'b000, 3'b000);
    cyc("R5", 12'h015, 1, 1, 1, 8'h05, 3'b000, 3'b000);
    cyc("R5", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R6 acknowledge clears its own flag only
    cyc("R6", 12'h000, 0, 0, 0, 8'h00, 3'b111, 3'b000);
    cyc("R6", 12'h000, 0, 0, 0, 8'h00, 3'b000, 3'b010);
    cyc("R6", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b100);
    cyc("R6", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b001);
    cyc("R6", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R7 set wins over write-one and acknowledge
    cyc("R7", 12'h035, 0, 0, 1, 8'h07, 3'b011, 3'b000);
    cyc("R7", 12'h035, 0, 1, 0, 8'h00, 3'b100, 3'b100);
    cyc("R7", 12'h035, 0, 1, 1, 8'h03, 3'b001, 3'b001);
    cyc("R7", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R8 gating by per-source and global enables
    en = 3'b101;
    cyc("R8", 12'h000, 0, 0, 0, 8'h00, 3'b111, 3'b000);
    idle("R8");
    gie = 0;
    idle("R8");
    gie = 1; en = 3'b010;
    idle("R8");
    en = 3'b111;
    // R9 reads during events and acknowledges return pre-edge state
    cyc("R9", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b100);
    cyc("R9", 12'h035, 0, 1, 1, 8'h01, 3'b100, 3'b000);
    cyc("R9", 12'h035, 0, 1, 0, 8'h00, 3'b000, 3'b000);
    // R1 asynchronous reset mid-run
    rst_n = 0;
    #1;
    m_flags = '0;
    @(negedge clk);
    rst_n = 1;
    cyc("R1", 12'h015, 1, 1, 0, 8'h00, 3'b000, 3'b000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule